// File: doc/BRIEF.md
# Tagged-Word Memory with Conditional Access

This block is a small word memory in which each entry holds 64 data bits, a pointer bit and a synchronization bit. Every load and store names a condition that the synchronization bit has to meet before the access may take place. It also names an update that is applied to the bit once the access succeeds. The check, the data access and the tag update happen in one clock. A following request to the same word therefore always sees the finished result of the one before it. Producer/consumer hand-off (store-if-empty then set, load-if-full then clear) and atomic read-modify-write can be built from these requests alone.

A request is presented for one cycle with `req_valid`. The memory word is read, the condition is evaluated, and any writes are committed at that clock edge. The response is registered and appears on the following cycle. It carries the read data, the pointer bit and the synchronization bit as they stood before the access, plus a fail flag or an error flag. A request may be issued on every cycle.

Top module: `sync_tag_mem`

## Requirements
- R1: While reset is held, and on the first cycles after it, `rsp_valid` is 0. After reset every word reads back data 0, pointer 0 and synchronization bit 0.
- R2: `rsp_valid` is 1 on exactly the cycle after a cycle with `req_valid` = 1, and 0 otherwise.
- R3: A load (`req_op` = 0) whose condition holds returns the word's data on `rsp_rdata` and its pointer bit on `rsp_rptr`. `rsp_rsync` always shows the synchronization bit from before the access.
- R4: A store (`req_op` = 1) whose condition holds writes `req_wdata` and `req_wptr` into the word. A store returns 0 on `rsp_rdata` and `rsp_rptr`.
- R5: The condition code `req_pre` works as follows: 00 always passes, 01 passes only when the bit is 0, and 10 passes only when the bit is 1.
- R6: When the condition fails, `rsp_fail` is 1, `rsp_rdata` and `rsp_rptr` are 0, and the data, pointer bit and synchronization bit of the word are all left unchanged.
- R7: The condition code 11 is reserved. Such a request returns `rsp_err` = 1 and `rsp_fail` = 0, and it changes nothing in the word. `rsp_fail` and `rsp_err` are never 1 together.
- R8: After a passing access, the update code `req_post` sets the synchronization bit as follows: 00 leaves it as it is, 01 clears it, 10 sets it, and 11 inverts it.
- R9: Requests to the same address on back-to-back cycles behave as if fully serialized. The second request checks and returns the state left by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = load, 1 = store |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_wptr | input | 1 | Store pointer bit |
| req_pre | input | 2 | Condition on the synchronization bit |
| req_post | input | 2 | Update of the synchronization bit on success |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W | Loaded data, 0 for stores and rejected requests |
| rsp_rptr | output | 1 | Loaded pointer bit, 0 for stores and rejected requests |
| rsp_rsync | output | 1 | Synchronization bit before the access |
| rsp_fail | output | 1 | Condition not met |
| rsp_err | output | 1 | Reserved condition code used |

## Verification
The assertions assume that the request inputs are known whenever `req_valid` is high. They also assume that `req_addr` stays below the memory depth. The bench drives every field on each request, including reserved condition codes. It draws addresses only from the valid range, and it concentrates them on a few words so that conditional requests meet both tag states. It issues requests back to back, so that consecutive accesses to one word are checked against a sequential model.

// File: rtl/sync_tag_pkg.sv
package sync_tag_pkg;
  typedef enum logic [1:0] {
    PRE_ANY  = 2'b00,
    PRE_ZERO = 2'b01,
    PRE_ONE  = 2'b10,
    PRE_RSVD = 2'b11
  } pre_e;

  typedef enum logic [1:0] {
    POST_KEEP = 2'b00,
    POST_CLR  = 2'b01,
    POST_SET  = 2'b10,
    POST_INV  = 2'b11
  } post_e;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;
endpackage

// File: rtl/stm_rule.sv
module stm_rule
  import sync_tag_pkg::*;
(
  input  logic [1:0] pre,
  input  logic [1:0] post,
  input  logic       cur_sync,
  output logic       pass,
  output logic       fail,
  output logic       err,
  output logic       new_sync
);
  always_comb begin
    err  = 1'b0;
    fail = 1'b0;
    unique case (pre_e'(pre))
      PRE_ANY:  fail = 1'b0;
      PRE_ZERO: fail = cur_sync;
      PRE_ONE:  fail = ~cur_sync;
      default:  err  = 1'b1;
    endcase
    pass = ~err & ~fail;
  end

  always_comb begin
    unique case (post_e'(post))
      POST_KEEP: new_sync = cur_sync;
      POST_CLR:  new_sync = 1'b0;
      POST_SET:  new_sync = 1'b1;
      default:   new_sync = ~cur_sync;
    endcase
  end

  always_comb begin
    AST_PRE_RULE_EXCL: assert (!(fail && err) && (pass ^ (fail | err))); // R7
  end
endmodule

// File: rtl/stm_word_array.sv
module stm_word_array #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ptr,
  output logic              rd_sync,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ptr,
  input  logic              wr_sync_en,
  input  logic              wr_sync
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  ptr_q;
  logic [DEPTH-1:0]  sync_q;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    assign hit = (addr == ADDR_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[w] <= '0;
        ptr_q[w]  <= 1'b0;
      end else if (hit && wr_data_en) begin
        data_q[w] <= wr_data;
        ptr_q[w]  <= wr_ptr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q[w] <= 1'b0;
      end else if (hit && wr_sync_en) begin
        sync_q[w] <= wr_sync;
      end
    end
  end

  assign rd_data = data_q[addr];
  assign rd_ptr  = ptr_q[addr];
  assign rd_sync = sync_q[addr];
endmodule

// File: rtl/sync_tag_mem.sv
module sync_tag_mem
  import sync_tag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wptr,
  input  logic [1:0]        req_pre,
  input  logic [1:0]        req_post,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_rptr,
  output logic              rsp_rsync,
  output logic              rsp_fail,
  output logic              rsp_err
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sq;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_ok = rst_sq[1];

  logic [DATA_W-1:0] cur_data;
  logic              cur_ptr, cur_sync;
  logic              pass, fail, err, new_sync;
  logic              is_store;

  stm_rule u_rule (
    .pre      (req_pre),
    .post     (req_post),
    .cur_sync (cur_sync),
    .pass     (pass),
    .fail     (fail),
    .err      (err),
    .new_sync (new_sync)
  );

  assign is_store = (op_e'(req_op) == OP_STORE);

  stm_word_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk        (clk),
    .rst_n      (rst_ok),
    .addr       (req_addr),
    .rd_data    (cur_data),
    .rd_ptr     (cur_ptr),
    .rd_sync    (cur_sync),
    .wr_data_en (req_valid && pass && is_store),
    .wr_data    (req_wdata),
    .wr_ptr     (req_wptr),
    .wr_sync_en (req_valid && pass),
    .wr_sync    (new_sync)
  );

  // response next-state
  logic              rsp_valid_d, rsp_rptr_d, rsp_rsync_d, rsp_fail_d, rsp_err_d;
  logic [DATA_W-1:0] rsp_rdata_d;
  logic              load_ok;

  always_comb begin
    load_ok     = req_valid && pass && !is_store;
    rsp_valid_d = req_valid;
    rsp_rdata_d = load_ok ? cur_data : '0;
    rsp_rptr_d  = load_ok & cur_ptr;
    rsp_rsync_d = req_valid & cur_sync;
    rsp_fail_d  = req_valid & fail;
    rsp_err_d   = req_valid & err;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_rptr  <= 1'b0;
      rsp_rsync <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_rdata <= rsp_rdata_d;
      rsp_rptr  <= rsp_rptr_d;
      rsp_rsync <= rsp_rsync_d;
      rsp_fail  <= rsp_fail_d;
      rsp_err   <= rsp_err_d;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_ok)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_valid |=> !rsp_valid); // R2
  AST_ANY_NEVER_FAILS: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_pre == 2'b00) |=> !rsp_fail); // R5
  AST_RSVD_ERR: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_pre == 2'b11) |=> (rsp_err && !rsp_fail)); // R7
  AST_REJECT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_ok)
    (rsp_valid && (rsp_fail || rsp_err)) |-> (rsp_rdata == '0 && !rsp_rptr)); // R6
  AST_REJECT_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && !pass) |=> ($stable(cur_sync) || $past(req_addr) != req_addr)); // R6
endmodule

// File: tb/sync_tag_mem_tb.sv
module sync_tag_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0, req_wptr = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [1:0] req_pre = '0, req_post = '0;
  logic rsp_valid, rsp_rptr, rsp_rsync, rsp_fail, rsp_err;
  logic [DATA_W-1:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_tag_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wptr(req_wptr),
    .req_pre(req_pre), .req_post(req_post), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_rptr(rsp_rptr), .rsp_rsync(rsp_rsync),
    .rsp_fail(rsp_fail), .rsp_err(rsp_err));

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] m_data [DEPTH];
  logic              m_ptr  [DEPTH];
  logic              m_sync [DEPTH];

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic pre_ok(logic [1:0] pre, logic s);
    return (pre == 2'b00) || (pre == 2'b01 && !s) || (pre == 2'b10 && s);
  endfunction

  function automatic logic post_val(logic [1:0] post, logic s);
    case (post)
      2'b00:   return s;
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return ~s;
    endcase
  endfunction

  // issue one request at a falling edge, check its response one cycle later
  task automatic op(string req, logic st, int a, logic [DATA_W-1:0] wd,
                    logic wp, logic [1:0] pre, logic [1:0] post);
    logic e_err, e_fail, e_ok;
    req_valid = 1'b1; req_op = st; req_addr = ADDR_W'(a);
    req_wdata = wd; req_wptr = wp; req_pre = pre; req_post = post;
    e_err  = (pre == 2'b11);
    e_fail = !e_err && !pre_ok(pre, m_sync[a]);
    e_ok   = !e_err && !e_fail;
    @(posedge clk); @(negedge clk);
    chk({req, " R2 valid"}, 64'(rsp_valid), 64'(1));
    chk({req, " R5 fail"},  64'(rsp_fail), 64'(e_fail));
    chk({req, " R7 err"},   64'(rsp_err), 64'(e_err));
    chk({req, " R3 sync"},  64'(rsp_rsync), 64'(m_sync[a]));
    chk({req, " R3 data"},  rsp_rdata, (e_ok && !st) ? m_data[a] : '0);
    chk({req, " R3 ptr"},   64'(rsp_rptr), 64'(e_ok && !st && m_ptr[a]));
    if (e_ok) begin
      if (st) begin m_data[a] = wd; m_ptr[a] = wp; end
      m_sync[a] = post_val(post, m_sync[a]);
    end
  endtask

  task automatic look(string req, int a);
    op(req, 1'b0, a, '0, 1'b0, 2'b00, 2'b00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_ptr[i] = 0; m_sync[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(rsp_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 64'(rsp_valid), 64'(0));
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) look("R1 reset word", i);

    // producer/consumer hand-off
    op("R4 store if empty", 1'b1, 2, 64'hDEAD_BEEF_0123_4567, 1'b1, 2'b01, 2'b10);
    op("R6 second store fails", 1'b1, 2, 64'h1111, 1'b0, 2'b01, 2'b10);
    look("R6 unchanged after fail", 2);
    op("R3 load if full", 1'b0, 2, '0, 1'b0, 2'b10, 2'b01);
    op("R6 load empty fails", 1'b0, 2, '0, 1'b0, 2'b10, 2'b01);
    op("R7 reserved", 1'b1, 2, 64'h55, 1'b1, 2'b11, 2'b10);
    look("R7 unchanged after reserved", 2);
    // every update code in turn
    op("R8 set", 1'b0, 5, '0, 1'b0, 2'b00, 2'b10);
    op("R8 keep", 1'b0, 5, '0, 1'b0, 2'b00, 2'b00);
    op("R8 invert", 1'b0, 5, '0, 1'b0, 2'b00, 2'b11);
    op("R8 invert again", 1'b0, 5, '0, 1'b0, 2'b00, 2'b11);
    op("R8 clear", 1'b0, 5, '0, 1'b0, 2'b00, 2'b01);
    look("R9 after clear", 5);

    // idle gap
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 no response when idle", 64'(rsp_valid), 64'(0));

    // random back-to-back traffic on a few words (R9)
    for (int n = 0; n < 3000; n++) begin
      int a;
      a = ($urandom % 4 == 0) ? int'($urandom % DEPTH) : int'($urandom % 3);
      op("R9 random", 1'($urandom), a, {$urandom, $urandom}, 1'($urandom),
         2'($urandom), 2'($urandom));
    end
    for (int i = 0; i < DEPTH; i++) look("R6 final contents", i);

    req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 idle at end", 64'(rsp_valid), 64'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule